// File: doc/BRIEF.md
# Processor Reset Stretcher and Bus-Request Strap Sequencer

This block turns a board-level, active-low system reset into the reset that a processor sees. While the system reset is low, the processor reset output is held low at once, without waiting for a clock. After the system reset is released and resynchronised to the bus clock, the processor reset is held low for a long, programmable stretch of clocks, chosen so that it lasts about one millisecond at the bus clock rate. It is then released.

The block also drives a bus-request strap line that the processor samples on the clock where its reset goes inactive. The strap is pulled low for the whole reset period, which guarantees a setup margin before the release edge. It is kept low for a bounded number of clocks after that edge, then let go high. A status flag reports that the strap has been released. A fresh system reset at any point in the sequence restarts everything from the asserted state.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `rst_in_n` is low, `cpu_rst_n`, `breq_n` and `strap_done` are all low, and they go low without waiting for a clock edge when `rst_in_n` falls.
- R2: After `rst_in_n` rises, `cpu_rst_n` stays low for exactly SYNC_STAGES + STRETCH_EFF rising clock edges, where STRETCH_EFF is STRETCH_CYCLES raised to 4 if it is smaller.
- R3: `breq_n` is low on every clock in which `cpu_rst_n` is low.
- R4: `breq_n` has been low for at least 4 clocks when `cpu_rst_n` goes high.
- R5: `breq_n` goes high exactly HOLD_EFF clocks after `cpu_rst_n` goes high, where HOLD_EFF is HOLD_CYCLES clamped into the range 2 to 20.
- R6: `strap_done` goes high on the same edge as `breq_n` and stays high, and once high neither `cpu_rst_n` nor `breq_n` falls again until the next system reset.
- R7: If `rst_in_n` falls at any point in the sequence, all outputs return to the state of R1, and the next release repeats the full timing of R2 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_in_n | input | 1 | Asynchronous active-low system reset |
| cpu_rst_n | output | 1 | Active-low processor reset |
| breq_n | output | 1 | Active-low bus-request strap line |
| strap_done | output | 1 | High once the strap has been released |

## Verification
The hardest case to reach is a system reset that arrives partway through the sequence. It can land in the resynchroniser, in the long stretch, in the strap hold window, or just after release, and in each case a full second sequence must follow with unchanged timing. The bench sweeps the point of reassertion one clock at a time across the whole sequence of a short-stretch configuration. It drops the reset between clock edges so that the asynchronous return can be seen before any edge, then measures the complete restarted sequence. Three instances with different parameters show the clamping of both the stretch and the hold counts.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        PH_WAIT    = 2'd0,  // system reset still resynchronising
        PH_STRETCH = 2'd1,  // processor reset held, counting the stretch
        PH_STRAP   = 2'd2,  // processor reset released, strap still low
        PH_RUN     = 2'd3   // strap released, sequence complete
    } phase_e;

    localparam int unsigned SETUP_MIN = 4;
    localparam int unsigned HOLD_MIN  = 2;
    localparam int unsigned HOLD_MAX  = 20;

    function automatic int unsigned clamp_u(input int unsigned v,
                                            input int unsigned lo,
                                            input int unsigned hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic [STAGES:0]   shifted;

    always_comb begin
        shifted = {chain_q, 1'b1};
        chain_d = shifted[STAGES-1:0];
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned STRETCH_EFF = 100000,
    parameter int unsigned HOLD_EFF    = 4,
    parameter int unsigned CNT_W       = 17
) (
    input  logic clk,
    input  logic arst_n,
    input  logic go,
    output logic cpu_rst_n,
    output logic breq_n,
    output logic strap_done
);
    localparam logic [CNT_W-1:0] STRETCH_LAST = CNT_W'(STRETCH_EFF - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST    = CNT_W'(HOLD_EFF - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             cpu_n;
        logic             strap_n;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        phase:   PH_WAIT,
        cnt:     '0,
        cpu_n:   1'b0,
        strap_n: 1'b0,
        done:    1'b0
    };

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_WAIT: begin
                if (go) begin
                    seq_d.phase = PH_STRETCH;
                    seq_d.cnt   = '0;
                end
            end
            PH_STRETCH: begin
                if (seq_q.cnt == STRETCH_LAST) begin
                    seq_d.phase = PH_STRAP;
                    seq_d.cnt   = '0;
                    seq_d.cpu_n = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_STRAP: begin
                if (seq_q.cnt == HOLD_LAST) begin
                    seq_d.phase   = PH_RUN;
                    seq_d.cnt     = '0;
                    seq_d.strap_n = 1'b1;
                    seq_d.done    = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            PH_RUN: begin
                seq_d = seq_q;
            end
            default: seq_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) seq_q <= SEQ_RESET;
        else         seq_q <= seq_d;
    end

    assign cpu_rst_n  = seq_q.cpu_n;
    assign breq_n     = seq_q.strap_n;
    assign strap_done = seq_q.done;

endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq
    import rstseq_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 100000,
    parameter int unsigned HOLD_CYCLES    = 4,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_in_n,
    output logic cpu_rst_n,
    output logic breq_n,
    output logic strap_done
);
    localparam int unsigned STRETCH_EFF =
        (STRETCH_CYCLES < SETUP_MIN) ? SETUP_MIN : STRETCH_CYCLES;
    localparam int unsigned HOLD_EFF  = clamp_u(HOLD_CYCLES, HOLD_MIN, HOLD_MAX);
    localparam int unsigned CNT_MAX   = (STRETCH_EFF > HOLD_EFF) ? STRETCH_EFF : HOLD_EFF;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);
    localparam int unsigned SYNC_EFF  = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic rst_sync_n;

    rstseq_sync #(
        .STAGES (SYNC_EFF)
    ) u_sync (
        .clk    (clk),
        .arst_n (rst_in_n),
        .sync_n (rst_sync_n)
    );

    rstseq_ctrl #(
        .STRETCH_EFF (STRETCH_EFF),
        .HOLD_EFF    (HOLD_EFF),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .arst_n     (rst_in_n),
        .go         (rst_sync_n),
        .cpu_rst_n  (cpu_rst_n),
        .breq_n     (breq_n),
        .strap_done (strap_done)
    );

endmodule

// File: rtl/cpu_reset_seq_chk.sv
module cpu_reset_seq_chk
    import rstseq_pkg::*;
(
    input logic clk,
    input logic rst_in_n,
    input logic cpu_rst_n,
    input logic breq_n,
    input logic strap_done
);
    logic [7:0] setup_cnt_q, hold_cnt_q;

    always_ff @(posedge clk or negedge rst_in_n) begin
        if (!rst_in_n) begin
            setup_cnt_q <= '0;
            hold_cnt_q  <= '0;
        end else begin
            if (!cpu_rst_n && !breq_n && setup_cnt_q != 8'hFF)
                setup_cnt_q <= setup_cnt_q + 8'd1;
            if (cpu_rst_n && !breq_n && hold_cnt_q != 8'hFF)
                hold_cnt_q <= hold_cnt_q + 8'd1;
        end
    end

    AST_STRAP_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_in_n)
        !cpu_rst_n |-> !breq_n); // R3

    AST_SETUP_MARGIN: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(cpu_rst_n) |-> (setup_cnt_q >= 8'(SETUP_MIN))); // R4

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(breq_n) |-> (hold_cnt_q >= 8'(HOLD_MIN) && hold_cnt_q <= 8'(HOLD_MAX))); // R5

    AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_in_n)
        $rose(breq_n) |-> strap_done); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_in_n)
        strap_done |=> (strap_done && cpu_rst_n && breq_n)); // R6

    AST_CPU_NO_REFALL: assert property (@(posedge clk) disable iff (!rst_in_n)
        cpu_rst_n |=> cpu_rst_n); // R7

endmodule

bind cpu_reset_seq cpu_reset_seq_chk u_chk (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .cpu_rst_n  (cpu_rst_n),
    .breq_n     (breq_n),
    .strap_done (strap_done)
);

// File: tb/tb_cpu_reset_seq.sv
`timescale 1ns/1ps
module tb_cpu_reset_seq;

    logic clk = 1'b0;
    logic rst_in_n = 1'b0;
    always #2.5 clk = ~clk;

    wire [2:0] cpu_v, breq_v, done_v;

    // config 0: stretch 10, hold 4; config 1: stretch 1 -> 4, hold 25 -> 20;
    // config 2: stretch 6, hold 1 -> 2
    cpu_reset_seq #(.STRETCH_CYCLES(10), .HOLD_CYCLES(4),  .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_in_n(rst_in_n),
        .cpu_rst_n(cpu_v[0]), .breq_n(breq_v[0]), .strap_done(done_v[0]));
    cpu_reset_seq #(.STRETCH_CYCLES(1),  .HOLD_CYCLES(25), .SYNC_STAGES(2)) dut_b (
        .clk(clk), .rst_in_n(rst_in_n),
        .cpu_rst_n(cpu_v[1]), .breq_n(breq_v[1]), .strap_done(done_v[1]));
    cpu_reset_seq #(.STRETCH_CYCLES(6),  .HOLD_CYCLES(1),  .SYNC_STAGES(2)) dut_c (
        .clk(clk), .rst_in_n(rst_in_n),
        .cpu_rst_n(cpu_v[2]), .breq_n(breq_v[2]), .strap_done(done_v[2]));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    function automatic int exp_low(input int i);
        int s;
        s = (i == 0) ? 10 : (i == 1) ? 1 : 6;
        if (s < 4) s = 4;
        return s + 2;
    endfunction

    function automatic int exp_hold(input int i);
        int h;
        h = (i == 0) ? 4 : (i == 1) ? 25 : 1;
        if (h < 2) h = 2;
        if (h > 20) h = 20;
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // reset is low; all outputs must read low
    task automatic check_reset_state(input string req);
        for (int i = 0; i < 3; i++) begin
            chk(cpu_v[i] == 1'b0, req, int'(cpu_v[i]), 0);
            chk(breq_v[i] == 1'b0, req, int'(breq_v[i]), 0);
            chk(done_v[i] == 1'b0, req, int'(done_v[i]), 0);
        end
    endtask

    // release reset just after a falling edge, then tally a full sequence
    task automatic run_sequence(input string tag);
        int low_cnt[3];
        int hold_cnt[3];
        int r3_bad[3];
        int r6_bad[3];
        bit seen_up[3];
        bit seen_done[3];
        for (int i = 0; i < 3; i++) begin
            low_cnt[i] = 0; hold_cnt[i] = 0; r3_bad[i] = 0; r6_bad[i] = 0;
            seen_up[i] = 1'b0; seen_done[i] = 1'b0;
        end
        @(negedge clk);
        rst_in_n = 1'b1;
        for (int n = 0; n < 45; n++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                if (!cpu_v[i]) begin
                    if (seen_up[i]) r6_bad[i]++;
                    else low_cnt[i]++;
                    if (breq_v[i]) r3_bad[i]++;
                end else begin
                    seen_up[i] = 1'b1;
                    if (!breq_v[i]) begin
                        if (seen_done[i]) r6_bad[i]++;
                        else hold_cnt[i]++;
                    end
                end
                if (done_v[i] != (breq_v[i] && cpu_v[i])) r6_bad[i]++;
                if (done_v[i]) seen_done[i] = 1'b1;
                else if (seen_done[i]) r6_bad[i]++;
            end
        end
        for (int i = 0; i < 3; i++) begin
            chk(low_cnt[i] == exp_low(i), {"R2 ", tag}, low_cnt[i], exp_low(i));
            chk(r3_bad[i] == 0, {"R3 ", tag}, r3_bad[i], 0);
            chk(low_cnt[i] >= 4, {"R4 ", tag}, low_cnt[i], 4);
            chk(hold_cnt[i] == exp_hold(i), {"R5 ", tag}, hold_cnt[i], exp_hold(i));
            chk(r6_bad[i] == 0 && done_v[i], {"R6 ", tag}, r6_bad[i], 0);
        end
    endtask

    initial begin
        // R1: reset state with reset held from time zero
        repeat (3) @(negedge clk);
        check_reset_state("R1 initial");

        run_sequence("first release");

        // R7: drop reset between edges at every point of a sequence
        for (int k = 0; k < 26; k++) begin
            @(negedge clk);
            rst_in_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_in_n = 1'b1;
            repeat (k) @(negedge clk);
            #1;
            rst_in_n = 1'b0;
            #0.5;
            check_reset_state("R1 R7 async reassert");
            repeat (2) @(negedge clk);
            check_reset_state("R7 held");
            run_sequence("R7 restart");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule